// File: doc/BRIEF.md
# Pointer-Indirect Load/Store Unit

This unit carries out the register-indirect data-memory transfers of a small 8-bit core. Three 16-bit pointers live in the top six general registers as byte pairs: pointer select 0 is r27:r26, select 1 is r29:r28 and select 2 is r31:r30. In each pair the even register holds the low byte. The unit takes a decoded request made of a direction, a pointer select, an addressing mode, a 6-bit displacement and a data register index. It reads the chosen pointer and the source register from the register file, forms the effective address and performs one memory read or write. It then returns the load data and the modified pointer bytes to the register file. No status flag is touched.

A request is accepted only while the unit is idle. The access takes exactly two cycles. The first is the access cycle, with `busy` high and the memory strobes driven. The second is the completion cycle, with `done` high and all register-file writes driven. Memory is assumed to have a synchronous read: read data is registered at the end of the access cycle and is consumed during the completion cycle. The register file is read combinationally when the request is accepted and is written at the clock edge that ends the completion cycle.

Top module: `ptr_ldst_unit`

## Requirements
- R1: Pointer select 0, 1 and 2 use the register pairs r27:r26, r29:r28 and r31:r30 respectively. The even register is the low byte, and `rfPtrRdIdx` and `rfPtrWrBase` carry the even index.
- R2: Mode 0 (plain) accesses the address held in the pointer and writes no pointer byte back.
- R3: Mode 1 (post-increment) accesses the pointer's current value and then writes pointer+1 back into both bytes of the pair.
- R4: Mode 2 (pre-decrement) accesses pointer-1 and writes pointer-1 back into both bytes of the pair.
- R5: Mode 3 (displacement) adds the unsigned 6-bit `reqDisp` to the pointer modulo 2^16. It is legal with pointer selects 1 and 2 only and writes no pointer byte back.
- R6: A request with pointer select 3, or with mode 3 on pointer select 0, is ignored: `busy` stays low, and neither memory nor register file changes.
- R7: After reset `busy`, `done` and all write and read strobes are low. An accepted request raises `busy` for exactly the next cycle, with the memory strobes driven, and then raises `done` for exactly one cycle, in which all register-file writes happen.
- R8: When `reqStore` is 1, the unit writes the value that register `reqReg` held when the request was accepted to memory. When `reqStore` is 0, it writes the addressed memory byte into register `reqReg`. Any of r0..r31 may be used.
- R9: Pointer increment and decrement wrap modulo 2^16 (0xFFFF+1 gives 0x0000, 0x0000-1 gives 0xFFFF).
- R10: If a load's destination is a byte of the pointer being incremented or decremented, that register ends up holding the loaded byte. The other byte of the pair still receives the updated pointer byte.
- R11: A request presented while `busy` or `done` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqPtrSel | input | 2 | Pointer select (0,1,2 valid) |
| reqMode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| reqDisp | input | 6 | Unsigned displacement |
| reqReg | input | 5 | Data register index |
| busy | output | 1 | Access cycle |
| done | output | 1 | Completion cycle |
| rfPtrRdIdx | output | 5 | Even register index of the selected pointer (read) |
| rfPtrLo | input | 8 | Register file value at `rfPtrRdIdx` |
| rfPtrHi | input | 8 | Register file value at `rfPtrRdIdx`+1 |
| rfSrcIdx | output | 5 | Store source register index (read) |
| rfSrcData | input | 8 | Register file value at `rfSrcIdx` |
| memAddr | output | 16 | Data memory address |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 8 | Memory write data |
| memRdData | input | 8 | Memory read data, valid the cycle after `memRdEn` |
| rfDataWrEn | output | 1 | Load data write enable |
| rfDataWrIdx | output | 5 | Load destination register |
| rfDataWrData | output | 8 | Load data |
| rfPtrWrBase | output | 5 | Even register index for pointer write-back |
| rfPtrLoWrEn | output | 1 | Pointer low-byte write enable |
| rfPtrHiWrEn | output | 1 | Pointer high-byte write enable |
| rfPtrLoWrData | output | 8 | Updated pointer low byte |
| rfPtrHiWrData | output | 8 | Updated pointer high byte |

## Verification
The hardest case to reach from the ports is a load whose destination is a byte of the pointer it is auto-modifying. Here the unit drives two writes at one register in the same cycle, and the data write must win. Random stimulus almost never picks such a combination, so directed operations load into r26 with X post-incremented and into r31 with Z pre-decremented. The same directed set covers pointer wraparound at 0xFFFF and 0x0000 and requests presented during `busy` and `done`. Random operations over all pointer, mode and register combinations then run against a bench model of the register file and memory.

// File: rtl/ptr_ldst_pkg.sv
package ptr_ldst_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN   = 2'd0,
    MODE_POSTINC = 2'd1,
    MODE_PREDEC  = 2'd2,
    MODE_DISP    = 2'd3
  } addrMode_e;

  typedef enum logic [1:0] {
    SEL_X    = 2'd0,
    SEL_Y    = 2'd1,
    SEL_Z    = 2'd2,
    SEL_NONE = 2'd3
  } ptrSel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FINISH = 2'd2
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch request, pointer and store data
    logic memAccess;  // drive memory strobes
    logic writeBack;  // drive register-file writes
  } ctlStrobes_t;

endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ptr_ldst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqPtrSel,
  input  logic [1:0]  reqMode,
  output ctlStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  ctlState_e state, stateNext;
  logic      reqLegal;

  // displacement is only allowed on Y and Z; select 3 names no pointer
  always_comb begin
    reqLegal = reqValid;
    if (ptrSel_e'(reqPtrSel) == SEL_NONE) reqLegal = 1'b0;
    if (ptrSel_e'(reqPtrSel) == SEL_X && addrMode_e'(reqMode) == MODE_DISP) reqLegal = 1'b0;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqLegal) stateNext = ST_ACCESS;
      ST_ACCESS: stateNext = ST_FINISH;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.capture   = (state == ST_IDLE) && reqLegal;
    strobes.memAccess = (state == ST_ACCESS);
    strobes.writeBack = (state == ST_FINISH);
  end

  assign busy = (state == ST_ACCESS);
  assign done = (state == ST_FINISH);

endmodule

// File: rtl/ldst_dpath.sv
module ldst_dpath
  import ptr_ldst_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int REG_CNT = 32,
  parameter int DISP_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              reqStore,
  input  logic [1:0]        reqPtrSel,
  input  logic [1:0]        reqMode,
  input  logic [DISP_W-1:0] reqDisp,
  input  logic [$clog2(REG_CNT)-1:0] reqReg,
  output logic [$clog2(REG_CNT)-1:0] rfPtrRdIdx,
  input  logic [DATA_W-1:0] rfPtrLo,
  input  logic [DATA_W-1:0] rfPtrHi,
  output logic [$clog2(REG_CNT)-1:0] rfSrcIdx,
  input  logic [DATA_W-1:0] rfSrcData,
  output logic [2*DATA_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              rfDataWrEn,
  output logic [$clog2(REG_CNT)-1:0] rfDataWrIdx,
  output logic [DATA_W-1:0] rfDataWrData,
  output logic [$clog2(REG_CNT)-1:0] rfPtrWrBase,
  output logic              rfPtrLoWrEn,
  output logic              rfPtrHiWrEn,
  output logic [DATA_W-1:0] rfPtrLoWrData,
  output logic [DATA_W-1:0] rfPtrHiWrData
);

  localparam int ADDR_W   = 2 * DATA_W;
  localparam int IDX_W    = $clog2(REG_CNT);
  localparam int PTR_BASE = REG_CNT - 6;

  function automatic logic [IDX_W-1:0] ptrBaseIdx(input logic [1:0] sel);
    ptrBaseIdx = IDX_W'(PTR_BASE + 2 * int'(sel));
  endfunction

  // captured operation
  logic              opStore;
  addrMode_e         opMode;
  logic [1:0]        opPtrSel;
  logic [DISP_W-1:0] opDisp;
  logic [IDX_W-1:0]  opReg;
  logic [ADDR_W-1:0] opPtr;
  logic [DATA_W-1:0] opSrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opStore  <= 1'b0;
      opMode   <= MODE_PLAIN;
      opPtrSel <= '0;
      opDisp   <= '0;
      opReg    <= '0;
      opPtr    <= '0;
      opSrc    <= '0;
    end else if (strobes.capture) begin
      opStore  <= reqStore;
      opMode   <= addrMode_e'(reqMode);
      opPtrSel <= reqPtrSel;
      opDisp   <= reqDisp;
      opReg    <= reqReg;
      opPtr    <= {rfPtrHi, rfPtrLo};
      opSrc    <= rfSrcData;
    end
  end

  assign rfPtrRdIdx = ptrBaseIdx(reqPtrSel);
  assign rfSrcIdx   = reqReg;

  // address and pointer update, both modulo 2^ADDR_W
  logic [ADDR_W-1:0] ptrInc, ptrDec, effAddr, newPtr;
  logic              ptrUpdate;

  assign ptrInc = opPtr + ADDR_W'(1);
  assign ptrDec = opPtr - ADDR_W'(1);

  always_comb begin
    effAddr   = opPtr;
    newPtr    = opPtr;
    ptrUpdate = 1'b0;
    unique case (opMode)
      MODE_POSTINC: begin newPtr = ptrInc; ptrUpdate = 1'b1; end
      MODE_PREDEC:  begin effAddr = ptrDec; newPtr = ptrDec; ptrUpdate = 1'b1; end
      MODE_DISP:    effAddr = opPtr + ADDR_W'(opDisp);
      default:      ;
    endcase
  end

  assign memAddr   = effAddr;
  assign memRdEn   = strobes.memAccess && !opStore;
  assign memWrEn   = strobes.memAccess && opStore;
  assign memWrData = opSrc;

  // write-back; load data wins over a pointer byte write to the same register
  logic [IDX_W-1:0] wbBase;
  logic             loadWb, hitLo, hitHi;

  assign wbBase = ptrBaseIdx(opPtrSel);
  assign loadWb = strobes.writeBack && !opStore;
  assign hitLo  = loadWb && (opReg == wbBase);
  assign hitHi  = loadWb && (opReg == (wbBase | IDX_W'(1)));

  assign rfDataWrEn    = loadWb;
  assign rfDataWrIdx   = opReg;
  assign rfDataWrData  = memRdData;
  assign rfPtrWrBase   = wbBase;
  assign rfPtrLoWrEn   = strobes.writeBack && ptrUpdate && !hitLo;
  assign rfPtrHiWrEn   = strobes.writeBack && ptrUpdate && !hitHi;
  assign rfPtrLoWrData = newPtr[DATA_W-1:0];
  assign rfPtrHiWrData = newPtr[ADDR_W-1:DATA_W];

endmodule

// File: rtl/ptr_ldst_unit.sv
module ptr_ldst_unit
  import ptr_ldst_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int REG_CNT = 32,
  parameter int DISP_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqPtrSel,
  input  logic [1:0]        reqMode,
  input  logic [DISP_W-1:0] reqDisp,
  input  logic [$clog2(REG_CNT)-1:0] reqReg,
  output logic              busy,
  output logic              done,
  output logic [$clog2(REG_CNT)-1:0] rfPtrRdIdx,
  input  logic [DATA_W-1:0] rfPtrLo,
  input  logic [DATA_W-1:0] rfPtrHi,
  output logic [$clog2(REG_CNT)-1:0] rfSrcIdx,
  input  logic [DATA_W-1:0] rfSrcData,
  output logic [2*DATA_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              rfDataWrEn,
  output logic [$clog2(REG_CNT)-1:0] rfDataWrIdx,
  output logic [DATA_W-1:0] rfDataWrData,
  output logic [$clog2(REG_CNT)-1:0] rfPtrWrBase,
  output logic              rfPtrLoWrEn,
  output logic              rfPtrHiWrEn,
  output logic [DATA_W-1:0] rfPtrLoWrData,
  output logic [DATA_W-1:0] rfPtrHiWrData
);

  ctlStrobes_t strobes;

  ldst_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqPtrSel (reqPtrSel),
    .reqMode   (reqMode),
    .strobes   (strobes),
    .busy      (busy),
    .done      (done)
  );

  ldst_dpath #(.DATA_W(DATA_W), .REG_CNT(REG_CNT), .DISP_W(DISP_W)) i_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .reqStore      (reqStore),
    .reqPtrSel     (reqPtrSel),
    .reqMode       (reqMode),
    .reqDisp       (reqDisp),
    .reqReg        (reqReg),
    .rfPtrRdIdx    (rfPtrRdIdx),
    .rfPtrLo       (rfPtrLo),
    .rfPtrHi       (rfPtrHi),
    .rfSrcIdx      (rfSrcIdx),
    .rfSrcData     (rfSrcData),
    .memAddr       (memAddr),
    .memRdEn       (memRdEn),
    .memWrEn       (memWrEn),
    .memWrData     (memWrData),
    .memRdData     (memRdData),
    .rfDataWrEn    (rfDataWrEn),
    .rfDataWrIdx   (rfDataWrIdx),
    .rfDataWrData  (rfDataWrData),
    .rfPtrWrBase   (rfPtrWrBase),
    .rfPtrLoWrEn   (rfPtrLoWrEn),
    .rfPtrHiWrEn   (rfPtrHiWrEn),
    .rfPtrLoWrData (rfPtrLoWrData),
    .rfPtrHiWrData (rfPtrHiWrData)
  );

endmodule

// File: rtl/ptr_ldst_chk.sv
module ptr_ldst_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic             memRdEn,
  input logic             memWrEn,
  input logic             rfDataWrEn,
  input logic [IDX_W-1:0] rfDataWrIdx,
  input logic [IDX_W-1:0] rfPtrWrBase,
  input logic             rfPtrLoWrEn,
  input logic             rfPtrHiWrEn
);

  // R7
  busy_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (done && !busy));

  // R11
  no_accept_in_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && !done));

  // R7
  mem_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn) |-> (busy && !(memRdEn && memWrEn)));

  // R7
  rf_only_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfDataWrEn || rfPtrLoWrEn || rfPtrHiWrEn) |-> done);

  // R10
  load_wins_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfDataWrEn && rfPtrLoWrEn) |-> (rfDataWrIdx != rfPtrWrBase));

  // R10
  load_wins_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfDataWrEn && rfPtrHiWrEn) |-> (rfDataWrIdx != (rfPtrWrBase | IDX_W'(1))));

  // R1
  ptr_base_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfPtrLoWrEn || rfPtrHiWrEn) |-> (rfPtrWrBase[0] == 1'b0));

endmodule

bind ptr_ldst_unit ptr_ldst_chk #(.IDX_W($clog2(REG_CNT))) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .done        (done),
  .memRdEn     (memRdEn),
  .memWrEn     (memWrEn),
  .rfDataWrEn  (rfDataWrEn),
  .rfDataWrIdx (rfDataWrIdx),
  .rfPtrWrBase (rfPtrWrBase),
  .rfPtrLoWrEn (rfPtrLoWrEn),
  .rfPtrHiWrEn (rfPtrHiWrEn)
);

// File: tb/test_ptr_ldst_unit.sv
`timescale 1ns/1ps
module test_ptr_ldst_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqStore = 1'b0;
  logic [1:0]  reqPtrSel = '0;
  logic [1:0]  reqMode = '0;
  logic [5:0]  reqDisp = '0;
  logic [4:0]  reqReg = '0;
  logic        busy, done;
  logic [4:0]  rfPtrRdIdx, rfSrcIdx, rfDataWrIdx, rfPtrWrBase;
  logic [7:0]  rfPtrLo, rfPtrHi, rfSrcData, memWrData, rfDataWrData;
  logic [7:0]  rfPtrLoWrData, rfPtrHiWrData;
  logic [7:0]  memRdData = '0;
  logic [15:0] memAddr;
  logic        memRdEn, memWrEn, rfDataWrEn, rfPtrLoWrEn, rfPtrHiWrEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  // register file and memory models
  logic [7:0] rf [32];
  logic [7:0] mem [logic [15:0]];
  logic [7:0] expRf [32];
  logic [7:0] expMem [logic [15:0]];

  function automatic logic [7:0] memGet(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  assign rfPtrLo   = rf[rfPtrRdIdx];
  assign rfPtrHi   = rf[rfPtrRdIdx | 5'd1];
  assign rfSrcData = rf[rfSrcIdx];

  always @(posedge clk) begin
    if (memWrEn) mem[memAddr] = memWrData;
    if (memRdEn) memRdData <= memGet(memAddr);
    if (rfPtrLoWrEn) rf[rfPtrWrBase] <= rfPtrLoWrData;
    if (rfPtrHiWrEn) rf[rfPtrWrBase | 5'd1] <= rfPtrHiWrData;
    if (rfDataWrEn) rf[rfDataWrIdx] <= rfDataWrData;
  end

  ptr_ldst_unit i_ptr_ldst_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqPtrSel(reqPtrSel), .reqMode(reqMode), .reqDisp(reqDisp), .reqReg(reqReg),
    .busy(busy), .done(done), .rfPtrRdIdx(rfPtrRdIdx), .rfPtrLo(rfPtrLo),
    .rfPtrHi(rfPtrHi), .rfSrcIdx(rfSrcIdx), .rfSrcData(rfSrcData),
    .memAddr(memAddr), .memRdEn(memRdEn), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdData(memRdData), .rfDataWrEn(rfDataWrEn), .rfDataWrIdx(rfDataWrIdx),
    .rfDataWrData(rfDataWrData), .rfPtrWrBase(rfPtrWrBase), .rfPtrLoWrEn(rfPtrLoWrEn),
    .rfPtrHiWrEn(rfPtrHiWrEn), .rfPtrLoWrData(rfPtrLoWrData), .rfPtrHiWrData(rfPtrHiWrData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit isLegal(input logic [1:0] sel, input logic [1:0] mode);
    return (sel != 2'd3) && !(sel == 2'd0 && mode == 2'd3);
  endfunction

  function automatic string modeReq(input logic [1:0] mode);
    case (mode)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // one operation; overlap presents a second request during busy and done (R11)
  task automatic doOp(input bit st, input logic [1:0] sel, input logic [1:0] mode,
                      input logic [5:0] disp, input logic [4:0] rg, input bit overlap);
    logic [4:0]  base;
    logic [15:0] ptr, addr, nptr;
    bit          legal;
    string       req;
    legal = isLegal(sel, mode);
    req   = modeReq(mode);
    foreach (rf[i]) expRf[i] = rf[i];
    expMem = mem;
    if (legal) begin
      base = 5'd26 + {2'b00, sel, 1'b0};   // R1 pairs
      ptr  = {rf[base | 5'd1], rf[base]};
      nptr = ptr;
      addr = ptr;
      case (mode)
        2'd1: nptr = ptr + 16'd1;
        2'd2: begin nptr = ptr - 16'd1; addr = nptr; end
        2'd3: addr = ptr + {10'd0, disp};
        default: ;
      endcase
      if (st) expMem[addr] = rf[rg];
      expRf[base]        = nptr[7:0];
      expRf[base | 5'd1] = nptr[15:8];
      if (!st) expRf[rg] = memGet(addr);   // R10: data wins
    end
    @(negedge clk);
    reqValid = 1'b1; reqStore = st; reqPtrSel = sel; reqMode = mode;
    reqDisp = disp; reqReg = rg;
    @(posedge clk); #1;
    if (overlap) begin
      reqStore = ~st; reqPtrSel = 2'd1; reqMode = 2'd1; reqReg = 5'd3;
    end else begin
      reqValid = 1'b0;
    end
    if (legal) begin
      check(busy === 1'b1 && done === 1'b0, "R7 busy", {busy, done}, 2'b10);
      check(memAddr === addr, req, memAddr, addr);
      check(memWrEn === st && memRdEn === !st, "R8 strobe", {memWrEn, memRdEn}, {st, !st});
      @(posedge clk); #1;
      check(done === 1'b1 && busy === 1'b0, "R7 done", {busy, done}, 2'b01);
      @(posedge clk); #1;
      reqValid = 1'b0;
      check(busy === 1'b0 && done === 1'b0, "R11 idle", {busy, done}, 2'b00);
    end else begin
      check(busy === 1'b0 && done === 1'b0, "R6 ignored", {busy, done}, 2'b00);
      reqValid = 1'b0;
      @(posedge clk); #1;
    end
    for (int i = 0; i < 32; i++)
      check(rf[i] === expRf[i], legal ? (st ? req : "R8 load") : "R6 rf", {i[7:0], rf[i]}, {i[7:0], expRf[i]});
    if (legal && st) check(memGet(addr) === expMem[addr], "R8 store", memGet(addr), expMem[addr]);
    if (!legal) check(mem.num() === expMem.num(), "R6 mem", mem.num(), expMem.num());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R7 watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < 32; i++) rf[i] = 8'($urandom);
    for (int i = 0; i < 64; i++) mem[16'($urandom)] = 8'($urandom);
    repeat (3) @(posedge clk);
    #1;
    check(busy === 0 && done === 0 && memRdEn === 0 && memWrEn === 0 && rfDataWrEn === 0,
          "R7 reset", {busy, done, memRdEn, memWrEn, rfDataWrEn}, 0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R1 / R2: plain load through each pointer
    rf[26] = 8'h10; rf[27] = 8'h01; mem[16'h0110] = 8'hA5;
    doOp(0, 2'd0, 2'd0, 6'd0, 5'd4, 0);
    rf[28] = 8'h20; rf[29] = 8'h02; mem[16'h0220] = 8'h5C;
    doOp(0, 2'd1, 2'd0, 6'd0, 5'd5, 0);
    rf[30] = 8'h30; rf[31] = 8'h03;
    doOp(1, 2'd2, 2'd0, 6'd0, 5'd6, 0);
    // R3 / R9: post-increment wrap
    rf[26] = 8'hFF; rf[27] = 8'hFF; mem[16'hFFFF] = 8'h3E;
    doOp(0, 2'd0, 2'd1, 6'd0, 5'd0, 0);
    // R4 / R9: pre-decrement wrap
    rf[28] = 8'h00; rf[29] = 8'h00;
    doOp(1, 2'd1, 2'd2, 6'd0, 5'd17, 0);
    // R5: displacement with carry and 16-bit wrap
    rf[30] = 8'hF0; rf[31] = 8'hFF; mem[16'h002F] = 8'h77;
    doOp(0, 2'd2, 2'd3, 6'd63, 5'd9, 0);
    doOp(1, 2'd1, 2'd3, 6'd40, 5'd31, 0);
    // R6: illegal combinations
    doOp(1, 2'd0, 2'd3, 6'd5, 5'd1, 0);
    doOp(0, 2'd3, 2'd1, 6'd0, 5'd2, 0);
    // R10: load into the pointer being modified
    rf[26] = 8'h40; rf[27] = 8'h00; mem[16'h0040] = 8'hC3;
    doOp(0, 2'd0, 2'd1, 6'd0, 5'd26, 0);
    rf[30] = 8'h01; rf[31] = 8'h05; mem[16'h0500] = 8'h9D;
    doOp(0, 2'd2, 2'd2, 6'd0, 5'd31, 0);
    // R8: store of a pointer byte uses its value at acceptance
    doOp(1, 2'd1, 2'd2, 6'd0, 5'd28, 0);
    // R11: requests during busy and done are ignored
    doOp(0, 2'd2, 2'd1, 6'd0, 5'd12, 1);
    doOp(1, 2'd1, 2'd0, 6'd0, 5'd13, 1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      doOp(1'($urandom), 2'($urandom), 2'($urandom), 6'($urandom), 5'($urandom),
           ($urandom % 8) == 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule